// File: doc/BRIEF.md
# Configurable Maximal-Length LFSR Generator

This block produces a pseudo-random sequence from an n-bit linear feedback shift register. The register width is fixed at elaboration. The feedback taps come from a built-in table of maximal-length positions, one entry per supported width. Two more choices are fixed at elaboration. The first is the topology: many-to-one, where the taps combine into one feedback bit, or one-to-many, where the top bit is gated into several positions. The second is the feedback gate: XOR or XNOR.

At run time the generator takes a seed load, a step enable and a full-cycle option. Without the full-cycle option it avoids its single lock-up state and repeats after 2^n−1 steps. With the option, it passes through the lock-up state once per period and repeats after 2^n steps.

The whole register is presented as a parallel word. Its top bit is presented as a serial output.

Top module: `lfsr_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the register loads its default seed. The default is 0…01 with XOR feedback and 1…10 with XNOR feedback.
- R2: When `load` is high at a rising edge, `state` equals `seed` after that edge, whatever `enable` is. Load takes priority over stepping.
- R3: The forbidden state is all zeros with XOR feedback and all ones with XNOR feedback. If `seed` equals the forbidden state while `full_cycle` is low, the load stores the default seed from R1 instead.
- R4: With `load` and `enable` both low, `state` keeps its value across the edge.
- R5: In many-to-one mode each step shifts `state` one place toward the MSB. Bit 0 then takes the XOR (or XNOR) of the tapped bits. Bit positions start at 0. The tap sets are: width 3 → {0,2}; width 4 → {0,3}; width 5 → {1,4}; width 8 → {1,2,3,7}.
- R6: In one-to-many mode the old MSB is the feedback source, using the tap sets of R5. It goes to bit 0. Every bit k+1 whose position k is a tap (k < n−1) takes bit k combined with that source. Every other bit k+1 takes bit k.
- R7: With XNOR feedback, each combining gate of R5 and R6 gives the complement of the XOR result.
- R8: With `full_cycle` low and `enable` held high, a legal seed state returns after exactly 2^n−1 steps. No state repeats inside that period.
- R9: With `full_cycle` high and `enable` held high, the period is exactly 2^n. No state repeats, and the forbidden state appears exactly once.
- R10: `serial_out` always equals bit n−1 of `state`.
- R11: With `full_cycle` low, a step from a legal state never produces the forbidden state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to the default seed |
| load | input | 1 | Load `seed` into the register this edge |
| seed | input | WIDTH | Seed value to load |
| enable | input | 1 | Advance the register by one step |
| full_cycle | input | 1 | Include the forbidden state in the sequence |
| state | output | WIDTH | Parallel register contents |
| serial_out | output | 1 | Serial output: MSB of the register |

## Verification
The assertions are checked on every cycle. They cover the reset value, the seed copy and its substitution, holding while idle, and the shift direction of each topology. They also check that the forbidden state is never entered without the full-cycle option.

Properties that span a whole period can only be shown by the bench's scenarios. These are the exact 2^n−1 or 2^n period length, the absence of repeated states, and the single visit to the forbidden state. The bench runs those scenarios for widths 3, 4, 5 and 8 in all four topology and gate combinations. A per-step model tracks every configuration through random loads, stalls and option changes.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

  typedef enum logic {
    TOPO_MANY_TO_ONE = 1'b0,
    TOPO_ONE_TO_MANY = 1'b1
  } topo_e;

  localparam int MAX_WIDTH = 24;

  // Maximal-length tap positions, bit k of the mask = register bit k.
  // Width 19 has no entry; the supported widths are 2..18 and 20..24.
  function automatic logic [MAX_WIDTH-1:0] tap_mask(input int width);
    case (width)
      2:       return 24'h000003;
      3:       return 24'h000005;
      4:       return 24'h000009;
      5:       return 24'h000012;
      6:       return 24'h000021;
      7:       return 24'h000041;
      8:       return 24'h00008E;
      9:       return 24'h000108;
      10:      return 24'h000204;
      11:      return 24'h000402;
      12:      return 24'h000829;
      13:      return 24'h00100D;
      14:      return 24'h002015;
      15:      return 24'h004001;
      16:      return 24'h008016;
      17:      return 24'h010004;
      18:      return 24'h020040;
      20:      return 24'h080004;
      21:      return 24'h100002;
      22:      return 24'h200001;
      23:      return 24'h400010;
      24:      return 24'h80000D;
      default: return 24'h000000;
    endcase
  endfunction

endpackage

// File: rtl/lfsr_step.sv
module lfsr_step
  import lfsr_pkg::*;
#(
  parameter int    WIDTH    = 8,
  parameter topo_e TOPOLOGY = TOPO_MANY_TO_ONE,
  parameter bit    USE_XNOR = 1'b0
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             full_cycle,
  output logic [WIDTH-1:0] nxt
);

  localparam logic [WIDTH-1:0] TAPS     = WIDTH'(tap_mask(WIDTH));
  localparam logic [WIDTH-2:0] LOW_LOCK = USE_XNOR ? {(WIDTH-1){1'b1}} : '0;
  localparam logic             INV      = USE_XNOR;

  // The lower bits match the lock-up pattern: flip the feedback so the
  // sequence detours through the lock-up state and back out again.
  logic detour;
  assign detour = full_cycle && (cur[WIDTH-2:0] == LOW_LOCK);

  generate
    if (TOPOLOGY == TOPO_MANY_TO_ONE) begin : g_many_to_one
      logic fb;
      assign fb  = (^(cur & TAPS)) ^ INV ^ detour;
      assign nxt = {cur[WIDTH-2:0], fb};
    end else begin : g_one_to_many
      logic src;
      assign src    = cur[WIDTH-1] ^ detour;
      assign nxt[0] = src;
      for (genvar k = 0; k < WIDTH-1; k++) begin : g_bit
        if (TAPS[k]) begin : g_tap
          assign nxt[k+1] = cur[k] ^ src ^ INV;
        end else begin : g_pass
          assign nxt[k+1] = cur[k];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/lfsr_seed_guard.sv
module lfsr_seed_guard #(
  parameter int WIDTH    = 8,
  parameter bit USE_XNOR = 1'b0
) (
  input  logic [WIDTH-1:0] seed,
  input  logic             full_cycle,
  output logic [WIDTH-1:0] safe_seed
);

  localparam logic [WIDTH-1:0] FORBID  = USE_XNOR ? {WIDTH{1'b1}} : '0;
  localparam logic [WIDTH-1:0] DEFAULT = USE_XNOR ? ~WIDTH'(1) : WIDTH'(1);

  always_comb begin
    if (!full_cycle && (seed == FORBID)) safe_seed = DEFAULT;
    else                                 safe_seed = seed;
  end

endmodule

// File: rtl/lfsr_gen.sv
module lfsr_gen
  import lfsr_pkg::*;
#(
  parameter int    WIDTH    = 8,
  parameter topo_e TOPOLOGY = TOPO_MANY_TO_ONE,
  parameter bit    USE_XNOR = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] seed,
  input  logic             enable,
  input  logic             full_cycle,
  output logic [WIDTH-1:0] state,
  output logic             serial_out
);

  localparam logic [WIDTH-1:0] DEFAULT = USE_XNOR ? ~WIDTH'(1) : WIDTH'(1);

  logic [WIDTH-1:0] step_val;
  logic [WIDTH-1:0] load_val;

  lfsr_step #(.WIDTH(WIDTH), .TOPOLOGY(TOPOLOGY), .USE_XNOR(USE_XNOR)) u_step (
    .cur        (state),
    .full_cycle (full_cycle),
    .nxt        (step_val)
  );

  lfsr_seed_guard #(.WIDTH(WIDTH), .USE_XNOR(USE_XNOR)) u_guard (
    .seed       (seed),
    .full_cycle (full_cycle),
    .safe_seed  (load_val)
  );

  always_ff @(posedge clk) begin
    if (rst)         state <= DEFAULT;
    else if (load)   state <= load_val;
    else if (enable) state <= step_val;
  end

  assign serial_out = state[WIDTH-1];

endmodule

// File: rtl/lfsr_gen_chk.sv
module lfsr_gen_chk
  import lfsr_pkg::*;
#(
  parameter int    WIDTH    = 8,
  parameter topo_e TOPOLOGY = TOPO_MANY_TO_ONE,
  parameter bit    USE_XNOR = 1'b0
) (
  input logic             clk,
  input logic             rst,
  input logic             load,
  input logic [WIDTH-1:0] seed,
  input logic             enable,
  input logic             full_cycle,
  input logic [WIDTH-1:0] state
);

  localparam logic [WIDTH-1:0] FORBID  = USE_XNOR ? {WIDTH{1'b1}} : '0;
  localparam logic [WIDTH-1:0] DEFAULT = USE_XNOR ? ~WIDTH'(1) : WIDTH'(1);

  p_reset_seed_r1: assert property (@(posedge clk)
    rst |=> state == DEFAULT);

  p_load_copy_r2: assert property (@(posedge clk) disable iff (rst)
    load && (seed != FORBID || full_cycle) |=> state == $past(seed));

  p_forbid_seed_r3: assert property (@(posedge clk) disable iff (rst)
    load && seed == FORBID && !full_cycle |=> state == DEFAULT);

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !load && !enable |=> $stable(state));

  p_no_lockup_r11: assert property (@(posedge clk) disable iff (rst)
    !load && !full_cycle && state != FORBID |=> state != FORBID);

  generate
    if (TOPOLOGY == TOPO_MANY_TO_ONE) begin : g_chk_m2o
      p_shift_r5: assert property (@(posedge clk) disable iff (rst)
        enable && !load |=> state[WIDTH-1:1] == $past(state[WIDTH-2:0]));
    end else begin : g_chk_o2m
      p_msb_src_r6: assert property (@(posedge clk) disable iff (rst)
        enable && !load && !full_cycle |=> state[0] == $past(state[WIDTH-1]));
    end
  endgenerate

endmodule

bind lfsr_gen lfsr_gen_chk #(.WIDTH(WIDTH), .TOPOLOGY(TOPOLOGY), .USE_XNOR(USE_XNOR)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .load       (load),
  .seed       (seed),
  .enable     (enable),
  .full_cycle (full_cycle),
  .state      (state)
);

// File: tb/tb_lfsr_gen.sv
`timescale 1ns/1ps
module tb_lfsr_gen;
  import lfsr_pkg::*;

  localparam int NCFG = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic       enable = 1'b0;
  logic       full_cycle = 1'b0;
  logic [7:0] seed = 8'h00;

  logic [7:0] st  [NCFG];
  logic       ser [NCFG];
  logic [7:0] expv [NCFG];

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;

  // Configuration i: width by i/4 (3,4,5,8), topology i%2, XNOR (i/2)%2
  for (genvar i = 0; i < NCFG; i++) begin : g_cfg
    localparam int W = (i/4 == 0) ? 3 : (i/4 == 1) ? 4 : (i/4 == 2) ? 5 : 8;
    logic [W-1:0] q;
    logic         so;
    lfsr_gen #(.WIDTH(W), .TOPOLOGY(topo_e'(i % 2)), .USE_XNOR(1'((i/2) % 2))) dut (
      .clk(clk), .rst(rst), .load(load), .seed(seed[W-1:0]), .enable(enable),
      .full_cycle(full_cycle), .state(q), .serial_out(so));
    assign st[i]  = 8'(q);
    assign ser[i] = so;
  end

  function automatic int cw(int i);
    return (i/4 == 0) ? 3 : (i/4 == 1) ? 4 : (i/4 == 2) ? 5 : 8;
  endfunction
  function automatic bit ctopo(int i); return bit'(i % 2); endfunction
  function automatic bit cxn(int i);   return bit'((i/2) % 2); endfunction
  function automatic logic [7:0] fm(int w); return 8'((9'd1 << w) - 9'd1); endfunction
  function automatic logic [7:0] forbid_of(int i); return cxn(i) ? fm(cw(i)) : 8'h00; endfunction
  function automatic logic [7:0] default_of(int i); return cxn(i) ? (fm(cw(i)) ^ 8'h01) : 8'h01; endfunction
  function automatic logic [7:0] taps_of(int w);
    case (w)
      3: return 8'b0000_0101;
      4: return 8'b0000_1001;
      5: return 8'b0001_0010;
      default: return 8'b1000_1110;
    endcase
  endfunction

  // Next-state model from R5, R6, R7 and the lock-up detour of R9
  function automatic logic [7:0] model_next(int i, logic [7:0] s, bit fc);
    int w = cw(i);
    logic [7:0] m = taps_of(w);
    logic [7:0] lowm = fm(w - 1);
    logic [7:0] r = 8'h00;
    bit z = fc && ((s & lowm) == (cxn(i) ? lowm : 8'h00));
    if (!ctopo(i)) begin
      bit p = ^(s & m);
      r = ((s << 1) | 8'(p ^ cxn(i) ^ z)) & fm(w);
    end else begin
      bit f = s[w-1] ^ z;
      r[0] = f;
      for (int k = 0; k < w - 1; k++)
        r[k+1] = m[k] ? (s[k] ^ f ^ cxn(i)) : s[k];
    end
    return r;
  endfunction

  function automatic logic [7:0] model_load(int i, logic [7:0] sd, bit fc);
    logic [7:0] v = sd & fm(cw(i));
    if (!fc && v == forbid_of(i)) return default_of(i);
    return v;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exv);
    end
  endtask

  // One clock: predict, wait for the edge, sample 1 ns later
  task automatic tick();
    for (int i = 0; i < NCFG; i++) begin
      if (rst)         expv[i] = default_of(i);
      else if (load)   expv[i] = model_load(i, seed, full_cycle);
      else if (enable) expv[i] = model_next(i, expv[i], full_cycle);
    end
    @(posedge clk);
    #1;
    for (int i = 0; i < NCFG; i++) begin
      // R2 R4 R5 R6 R7: cycle-accurate state against the model
      chk(st[i] == expv[i], ctopo(i) ? "R6" : "R5",
          $sformatf("cfg%0d w%0d xn%0d step", i, cw(i), cxn(i)), st[i], expv[i]);
      chk(ser[i] == st[i][cw(i)-1], "R10", $sformatf("cfg%0d serial", i),
          ser[i], st[i][cw(i)-1]);
    end
  endtask

  // R8 / R9: free run from a common seed, measure the period
  task automatic period_run(bit fc);
    int          period [NCFG];
    int          reps   [NCFG];
    int          forb   [NCFG];
    bit          done   [NCFG];
    logic [7:0]  s0     [NCFG];
    logic [255:0] vis   [NCFG];
    full_cycle = fc;
    load = 1'b1; seed = 8'h06; enable = 1'b0;
    tick();
    load = 1'b0; enable = 1'b1;
    for (int i = 0; i < NCFG; i++) begin
      s0[i] = st[i]; vis[i] = '0; vis[i][st[i]] = 1'b1;
      reps[i] = 0; period[i] = 0; done[i] = 1'b0;
      forb[i] = (st[i] == forbid_of(i)) ? 1 : 0;
    end
    for (int c = 1; c <= 256; c++) begin
      tick();
      for (int i = 0; i < NCFG; i++) begin
        if (!done[i]) begin
          if (st[i] == s0[i]) begin
            period[i] = c; done[i] = 1'b1;
          end else begin
            if (vis[i][st[i]]) reps[i]++;
            vis[i][st[i]] = 1'b1;
            if (st[i] == forbid_of(i)) forb[i]++;
          end
        end
      end
    end
    for (int i = 0; i < NCFG; i++) begin
      if (!fc) begin
        chk(period[i] == (1 << cw(i)) - 1, "R8", $sformatf("cfg%0d period", i),
            period[i], (1 << cw(i)) - 1);
        chk(reps[i] == 0, "R8", $sformatf("cfg%0d repeats", i), reps[i], 0);
        chk(forb[i] == 0, "R11", $sformatf("cfg%0d forbidden visits", i), forb[i], 0);
      end else begin
        chk(period[i] == (1 << cw(i)), "R9", $sformatf("cfg%0d period", i),
            period[i], 1 << cw(i));
        chk(reps[i] == 0, "R9", $sformatf("cfg%0d repeats", i), reps[i], 0);
        chk(forb[i] == 1, "R9", $sformatf("cfg%0d forbidden visits", i), forb[i], 1);
      end
    end
    enable = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", nchk, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] held [NCFG];
    int unsigned rs;
    rs = $urandom(32'h5EED_0C1A);

    // R1: reset state
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
    for (int i = 0; i < NCFG; i++)
      chk(st[i] == default_of(i), "R1", $sformatf("cfg%0d reset", i), st[i], default_of(i));

    period_run(1'b0);
    period_run(1'b1);

    // R4: idle with a changing seed bus
    full_cycle = 1'b0; load = 1'b0; enable = 1'b0;
    for (int i = 0; i < NCFG; i++) held[i] = st[i];
    for (int n = 0; n < 3; n++) begin
      seed = 8'($urandom);
      tick();
    end
    for (int i = 0; i < NCFG; i++)
      chk(st[i] == held[i], "R4", $sformatf("cfg%0d hold", i), st[i], held[i]);

    // R3: forbidden seeds replaced without the extension
    load = 1'b1; seed = 8'h00;
    tick();
    for (int i = 0; i < NCFG; i++)
      chk(st[i] == (cxn(i) ? 8'h00 : default_of(i)), "R3",
          $sformatf("cfg%0d zero seed", i), st[i], cxn(i) ? 8'h00 : default_of(i));
    seed = 8'hFF;
    tick();
    for (int i = 0; i < NCFG; i++)
      chk(st[i] == (cxn(i) ? default_of(i) : fm(cw(i))), "R3",
          $sformatf("cfg%0d ones seed", i), st[i], cxn(i) ? default_of(i) : fm(cw(i)));

    // R9: with the extension the forbidden seed is kept
    full_cycle = 1'b1; seed = 8'h00;
    tick();
    for (int i = 0; i < NCFG; i++)
      if (!cxn(i)) chk(st[i] == 8'h00, "R9", $sformatf("cfg%0d lockup load", i), st[i], 0);

    // R2: load wins over enable
    full_cycle = 1'b0; enable = 1'b1; seed = 8'hA5;
    tick();
    for (int i = 0; i < NCFG; i++)
      chk(st[i] == model_load(i, 8'hA5, 1'b0), "R2", $sformatf("cfg%0d load priority", i),
          st[i], model_load(i, 8'hA5, 1'b0));

    // Random mix of loads, stalls and option changes
    for (int n = 0; n < 600; n++) begin
      load = ($urandom % 8) == 0;
      enable = ($urandom % 4) != 0;
      if (($urandom % 16) == 0) full_cycle = ~full_cycle;
      seed = 8'($urandom);
      tick();
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule